// File: doc/BRIEF.md
# Priority-Ordered Shifting Match Table

This block is a small ternary match table. Its entries stay physically sorted by priority, so a lookup only has to pick the lowest-addressed entry that matches. Each entry holds a key, a care mask, a priority and an action word. Software-facing logic elsewhere drives three ports into it: insert, delete and lookup. Lookup is combinational and compares the key against every valid entry at once.

An insert first works out where the new rule belongs in the sorted order. It then opens that slot by copying the entries below it down one address per clock. A delete closes the hole it leaves by copying the entries below it up one address per clock. While entries are moving, `busy` is high, new requests are refused and lookups report a miss. Every accepted operation ends with a one-cycle `done` pulse carrying the number of entries moved. This makes the displacement cost of each update visible at the ports.

Top module: `prio_shift_table`

## Requirements
- R1: A lookup reports `lk_hit`=1 with the action and index of the lowest-indexed valid entry for which `(lk_key ^ key) & mask` is zero. A mask bit of 1 means that key bit is compared.
- R2: A lookup that matches no valid entry reports `lk_hit`=0.
- R3: A larger priority value means higher priority. An inserted rule is placed at an index equal to the number of stored entries whose priority is greater than or equal to its own. Stored entries therefore always stay in non-increasing priority order from index 0.
- R4: An insert whose priority exceeds that of every stored entry lands at index 0 and reports a move count equal to the prior occupancy.
- R5: An insert whose priority is less than or equal to every stored priority is appended with a move count of 0. Its `done` comes one cycle after acceptance whatever the occupancy, and `busy` never rises.
- R6: Deleting valid index d, with occupancy n, shifts entries d+1..n-1 up by one and reports n-1-d moves.
- R7: Exactly one entry moves per clock. For an operation with m>0 moves, `busy` is high for m cycles after the accepting edge, and `done` rises at the m-th edge after acceptance.
- R8: Insert or delete requests presented while `busy` is high are ignored.
- R9: An insert into a full table raises `err` for one cycle and produces no `done`. The table contents are left unchanged.
- R10: A delete of an index at or beyond the occupancy raises `err` for one cycle and leaves the table unchanged. When `ins_req` and `del_req` are both high, only the insert is acted on.
- R11: While `busy` is high, `lk_hit` is 0.
- R12: After reset the table is empty. `busy`, `done`, `err` and `lk_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_req | input | 1 | Insert request |
| ins_key | input | KEY_W | Key of the new rule |
| ins_mask | input | KEY_W | Care mask of the new rule (1 = compare) |
| ins_pri | input | PRI_W | Priority of the new rule (larger wins) |
| ins_act | input | ACT_W | Action of the new rule |
| del_req | input | 1 | Delete request |
| del_idx | input | IDX_W | Index to delete |
| lk_key | input | KEY_W | Lookup key |
| lk_hit | output | 1 | Lookup matched |
| lk_act | output | ACT_W | Action of the winning entry |
| lk_idx | output | IDX_W | Index of the winning entry |
| busy | output | 1 | Entries are moving |
| done | output | 1 | One-cycle pulse when an operation completes |
| moves | output | CNT_W | Entries moved by the completed operation |
| err | output | 1 | One-cycle pulse for a rejected insert or delete |

## Verification
A wrong internal state shows up in two ways. A pointer that stops at the wrong place shows in `moves`, and in the cycle at which `done` rises after an accepted request, on that very operation. Broken priority order or a lost entry shows on the lookup ports as the wrong `lk_idx` or `lk_act`, or as a missing hit, on the first lookup that reaches the damaged region. That lookup is made right after each operation. A refused request that still took effect shows as a mismatch on the lookups that follow the busy window.

// File: rtl/prio_shift_table.sv
module prio_shift_table #(
  parameter int DEPTH = 8,
  parameter int KEY_W = 8,
  parameter int PRI_W = 4,
  parameter int ACT_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_req,
  input  logic [KEY_W-1:0] ins_key,
  input  logic [KEY_W-1:0] ins_mask,
  input  logic [PRI_W-1:0] ins_pri,
  input  logic [ACT_W-1:0] ins_act,
  input  logic             del_req,
  input  logic [IDX_W-1:0] del_idx,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic [ACT_W-1:0] lk_act,
  output logic [IDX_W-1:0] lk_idx,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] moves,
  output logic             err
);

  typedef enum logic [1:0] {IDLE, SHDN, SHUP} st_t;

  logic [KEY_W-1:0] key_q  [DEPTH];
  logic [KEY_W-1:0] mask_q [DEPTH];
  logic [PRI_W-1:0] pri_q  [DEPTH];
  logic [ACT_W-1:0] act_q  [DEPTH];
  logic [DEPTH-1:0] valid_q;

  st_t              state;
  logic [CNT_W-1:0] occ;
  logic [IDX_W-1:0] ptr, tgt, last;
  logic [CNT_W-1:0] cnt;
  logic [KEY_W-1:0] p_key, p_mask;
  logic [PRI_W-1:0] p_pri;
  logic [ACT_W-1:0] p_act;

  logic [CNT_W-1:0] pos_c;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  assign busy = (state != IDLE);

  always_comb begin
    pos_c = '0;
    for (int i = 0; i < DEPTH; i++)
      if (valid_q[i] && pri_q[i] >= ins_pri) pos_c = pos_c + 1'b1;
  end

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (valid_q[i] && (((lk_key ^ key_q[i]) & mask_q[i]) == '0)) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end

  assign lk_hit = any_hit && !busy;
  assign lk_idx = hit_idx;
  assign lk_act = act_q[hit_idx];

  wire [CNT_W-1:0] ins_moves = occ - pos_c;
  wire [CNT_W-1:0] del_moves = occ - 1'b1 - CNT_W'(del_idx);
  wire             del_ok    = CNT_W'(del_idx) < occ;
  wire             full      = (occ == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      valid_q <= '0;
      occ     <= '0;
      ptr     <= '0;
      tgt     <= '0;
      last    <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      moves   <= '0;
      p_key   <= '0;
      p_mask  <= '0;
      p_pri   <= '0;
      p_act   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i]  <= '0;
        mask_q[i] <= '0;
        pri_q[i]  <= '0;
        act_q[i]  <= '0;
      end
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        IDLE: begin
          if (ins_req) begin
            if (full) begin
              err <= 1'b1;
            end else if (ins_moves == '0) begin
              key_q[occ[IDX_W-1:0]]  <= ins_key;
              mask_q[occ[IDX_W-1:0]] <= ins_mask;
              pri_q[occ[IDX_W-1:0]]  <= ins_pri;
              act_q[occ[IDX_W-1:0]]  <= ins_act;
              valid_q[occ[IDX_W-1:0]] <= 1'b1;
              occ   <= occ + 1'b1;
              done  <= 1'b1;
              moves <= '0;
            end else begin
              p_key  <= ins_key;
              p_mask <= ins_mask;
              p_pri  <= ins_pri;
              p_act  <= ins_act;
              ptr    <= occ[IDX_W-1:0];
              tgt    <= pos_c[IDX_W-1:0];
              cnt    <= '0;
              state  <= SHDN;
            end
          end else if (del_req) begin
            if (!del_ok) begin
              err <= 1'b1;
            end else if (del_moves == '0) begin
              valid_q[del_idx] <= 1'b0;
              occ   <= occ - 1'b1;
              done  <= 1'b1;
              moves <= '0;
            end else begin
              ptr   <= del_idx;
              last  <= IDX_W'(occ - 1'b1);
              cnt   <= '0;
              state <= SHUP;
            end
          end
        end
        SHDN: begin
          key_q[ptr]   <= key_q[ptr - 1'b1];
          mask_q[ptr]  <= mask_q[ptr - 1'b1];
          pri_q[ptr]   <= pri_q[ptr - 1'b1];
          act_q[ptr]   <= act_q[ptr - 1'b1];
          valid_q[ptr] <= 1'b1;
          if ((ptr - 1'b1) == tgt) begin
            key_q[tgt]  <= p_key;
            mask_q[tgt] <= p_mask;
            pri_q[tgt]  <= p_pri;
            act_q[tgt]  <= p_act;
            occ   <= occ + 1'b1;
            done  <= 1'b1;
            moves <= cnt + 1'b1;
            state <= IDLE;
          end else begin
            ptr <= ptr - 1'b1;
            cnt <= cnt + 1'b1;
          end
        end
        SHUP: begin
          key_q[ptr]  <= key_q[ptr + 1'b1];
          mask_q[ptr] <= mask_q[ptr + 1'b1];
          pri_q[ptr]  <= pri_q[ptr + 1'b1];
          act_q[ptr]  <= act_q[ptr + 1'b1];
          if ((ptr + 1'b1) == last) begin
            valid_q[last] <= 1'b0;
            occ   <= occ - 1'b1;
            done  <= 1'b1;
            moves <= cnt + 1'b1;
            state <= IDLE;
          end else begin
            ptr <= ptr + 1'b1;
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
    a_r3_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      (state == IDLE && valid_q[g+1]) |-> (valid_q[g] && pri_q[g] >= pri_q[g+1]));
  end

  a_r9_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ins_req && full) |=> (err && !done && occ == $past(occ)));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_hit);

  a_r6_moves_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (moves < CNT_W'(DEPTH)));

endmodule

// File: tb/sim_prio_shift_table.sv
module sim_prio_shift_table;
  localparam int DEPTH = 8, KEY_W = 8, PRI_W = 4, ACT_W = 8;
  localparam int IDX_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic ins_req = 0, del_req = 0;
  logic [KEY_W-1:0] ins_key = 0, ins_mask = 0, lk_key = 0;
  logic [PRI_W-1:0] ins_pri = 0;
  logic [ACT_W-1:0] ins_act = 0;
  logic [IDX_W-1:0] del_idx = 0;
  logic lk_hit, busy, done, err;
  logic [ACT_W-1:0] lk_act;
  logic [IDX_W-1:0] lk_idx;
  logic [CNT_W-1:0] moves;

  int checks = 0, errors = 0;
  logic [KEY_W-1:0] mk [DEPTH];
  logic [KEY_W-1:0] mm [DEPTH];
  logic [PRI_W-1:0] mp [DEPTH];
  logic [ACT_W-1:0] ma [DEPTH];
  int mocc = 0;

  always #10 clk = ~clk;

  prio_shift_table #(.DEPTH(DEPTH), .KEY_W(KEY_W), .PRI_W(PRI_W), .ACT_W(ACT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_req(ins_req), .ins_key(ins_key), .ins_mask(ins_mask),
    .ins_pri(ins_pri), .ins_act(ins_act), .del_req(del_req), .del_idx(del_idx),
    .lk_key(lk_key), .lk_hit(lk_hit), .lk_act(lk_act), .lk_idx(lk_idx), .busy(busy),
    .done(done), .moves(moves), .err(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pos(input logic [PRI_W-1:0] p);
    int n = 0;
    for (int i = 0; i < mocc; i++) if (mp[i] >= p) n++;
    return n;
  endfunction

  task automatic check_lookup(input logic [KEY_W-1:0] k);
    int e = -1;
    for (int i = mocc - 1; i >= 0; i--)
      if (((k ^ mk[i]) & mm[i]) == 0) e = i;
    lk_key = k;
    #1;
    if (e < 0) chk(lk_hit == 0, "R2 miss", lk_hit, 0);
    else begin
      chk(lk_hit == 1, "R1 hit", lk_hit, 1);
      chk(lk_idx == e, "R1 idx", lk_idx, e);
      chk(lk_act == ma[e], "R1 act", lk_act, ma[e]);
    end
  endtask

  task automatic do_insert(input logic [KEY_W-1:0] k, input logic [KEY_W-1:0] m,
                           input logic [PRI_W-1:0] p, input logic [ACT_W-1:0] a,
                           input bit poke_busy);
    int pos, em, n;
    pos = exp_pos(p);
    em = mocc - pos;
    ins_key = k; ins_mask = m; ins_pri = p; ins_act = a; ins_req = 1;
    @(negedge clk);
    ins_req = 0;
    if (mocc == DEPTH) begin
      chk(err == 1 && done == 0, "R9 full err", err, 1);
      return;
    end
    n = 0;
    while (!done && n < DEPTH + 2) begin
      chk(busy == 1, "R7 busy", busy, 1);
      chk(lk_hit == 0, "R11 stall", lk_hit, 0);
      if (poke_busy && n == 0) begin
        ins_req = 1; del_req = 1; del_idx = 0; ins_pri = '1;
      end
      @(negedge clk);
      ins_req = 0; del_req = 0;
      n++;
    end
    chk(n == em, "R7 done timing", n, em);
    chk(moves == em, (em == 0) ? "R5 moves" : "R3 R4 moves", moves, em);
    chk(busy == 0, "R7 busy low at done", busy, 0);
    for (int i = mocc; i > pos; i--) begin
      mk[i] = mk[i-1]; mm[i] = mm[i-1]; mp[i] = mp[i-1]; ma[i] = ma[i-1];
    end
    mk[pos] = k; mm[pos] = m; mp[pos] = p; ma[pos] = a;
    mocc++;
  endtask

  task automatic do_delete(input int d);
    int em, n;
    del_idx = IDX_W'(d); del_req = 1;
    @(negedge clk);
    del_req = 0;
    if (d >= mocc) begin
      chk(err == 1 && done == 0, "R10 bad index err", err, 1);
      return;
    end
    em = mocc - 1 - d;
    n = 0;
    while (!done && n < DEPTH + 2) begin
      chk(busy == 1, "R7 busy del", busy, 1);
      @(negedge clk);
      n++;
    end
    chk(n == em, "R6 done timing", n, em);
    chk(moves == em, "R6 moves", moves, em);
    for (int i = d; i < mocc - 1; i++) begin
      mk[i] = mk[i+1]; mm[i] = mm[i+1]; mp[i] = mp[i+1]; ma[i] = ma[i+1];
    end
    mocc--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R12 reset ctl", {busy, done, err}, 0);
    lk_key = 8'h00; #1;
    chk(lk_hit == 0, "R12 reset empty", lk_hit, 0);

    do_insert(8'h11, 8'hFF, 4'd2, 8'hA1, 0);
    do_insert(8'h22, 8'hFF, 4'd2, 8'hA2, 0);
    do_insert(8'h33, 8'hFF, 4'd2, 8'hA3, 0);
    do_insert(8'h10, 8'hF0, 4'd1, 8'hB0, 0);
    check_lookup(8'h11);
    check_lookup(8'h15);
    do_insert(8'h10, 8'hF0, 4'd9, 8'hC0, 1);
    check_lookup(8'h11);
    check_lookup(8'h15);
    check_lookup(8'h99);
    do_insert(8'h22, 8'hFF, 4'd2, 8'hA4, 0);
    do_insert(8'h00, 8'h00, 4'd5, 8'hD0, 0);
    do_insert(8'h44, 8'hFF, 4'd0, 8'hE0, 0);
    chk(mocc == DEPTH, "R9 fill", mocc, DEPTH);
    do_insert(8'h55, 8'hFF, 4'd15, 8'hF0, 0);
    check_lookup(8'h55);
    check_lookup(8'h44);
    do_delete(0);
    check_lookup(8'h22);
    do_delete(mocc - 1);
    do_delete(DEPTH - 1);
    check_lookup(8'h10);

    for (int it = 0; it < 300; it++) begin
      int r = $urandom % 3;
      if (r == 0 || mocc == 0)
        do_insert(KEY_W'($urandom % 16), KEY_W'($urandom | 8'hF0), PRI_W'($urandom % 4),
                  ACT_W'($urandom), 0);
      else
        do_delete($urandom % DEPTH);
      check_lookup(KEY_W'($urandom % 16));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule